// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Controller

The block owns a 16-bit pattern output split into four groups of four bits. Group n drives bits 4n+3..4n. Each group copies bits from a next-data register onto its outputs when a compare-match strobe arrives from one of four external timer channels. A per-group select field picks that channel.

Each group runs in one of two modes. In ordinary mode the whole group loads on compare match A. In non-overlap mode, falling bits are applied on compare match A and rising bits on compare match B. The gap between the A and B events therefore keeps complementary outputs from being high at the same time. Software reaches the registers through a simple single-cycle register bus with a combinational read path.

Top module: `pto_top`

## Requirements
- R1: After reset the pattern output, the next-data register and the trigger-select register are 0, and the mode register reads 0x00F0.
- R2: Register map on `reg_addr_i`:
  - 0 is next data, 16 bits, with group n taken from bits 4n+3..4n.
  - 1 is trigger select, 8 bits, with group n's field at bits 2n+1..2n.
  - 2 is the mode register.
  - 3 reads 0.
  
  Writes take effect at the clock edge where `reg_we_i` is sampled high. Reads are combinational.
- R3: Mode register bit n (n = 0..3) puts group n in non-overlap mode when 1. Bits 7..4 always read 1, and writes to them are ignored.
- R4: A trigger-select field value of 00, 01, 10 or 11 selects timer channel 0, 1, 2 or 3 respectively. Channel k is bit k of `cm_a_i` and of `cm_b_i`.
- R5: In ordinary mode, a group loads its next-data bits at the clock edge where compare match A of its selected channel is sampled high. Compare match B has no effect on that group.
- R6: In non-overlap mode, compare match A drives to 0 each bit whose next-data value is 0 and leaves the other bits unchanged.
- R7: In non-overlap mode, compare match B drives to 1 each bit whose next-data value is 1 and leaves the other bits unchanged.
- R8: In non-overlap mode, when A and B of the selected channel arrive in the same cycle, the group takes its next-data value.
- R9: Strobes on channels that a group has not selected leave that group's outputs unchanged.
- R10: Groups update independently: a strobe changes only the groups that selected its channel, each according to its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| cm_a_i | input | 4 | Compare match A strobes, one per timer channel |
| cm_b_i | input | 4 | Compare match B strobes, one per timer channel |
| pattern_o | output | 16 | Pattern output, four groups of four bits |

## Verification
A corrupted select field shows up on the first strobe: the group either ignores its own channel or follows a foreign one. The pattern port shows this one edge after the strobe. A wrong mode bit makes a group load whole nibbles where only falling or rising bits should move; this is visible on the first A-only or B-only strobe. A fault in the mode register's reserved bits or in the next-data register shows on the very next read, since reads are combinational.

// File: rtl/pto_pkg.sv
package pto_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_NEXT = 2'd0,
    REG_TSEL = 2'd1,
    REG_MODE = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
  localparam int MODE_W = 8;
endpackage

// File: rtl/pto_regs.sv
module pto_regs
  import pto_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GW     = 4,
  parameter int SEL_W  = 2,
  localparam int DW    = GROUPS * GW,
  localparam int TW    = GROUPS * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     next_o,
  output logic [TW-1:0]     tsel_o,
  output logic [GROUPS-1:0] nov_o
);
  logic [DW-1:0]     next_q;
  logic [TW-1:0]     tsel_q;
  logic [GROUPS-1:0] nov_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      tsel_q <= '0;
      nov_q  <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        REG_NEXT: next_q <= wdata_i;
        REG_TSEL: tsel_q <= wdata_i[TW-1:0];
        REG_MODE: nov_q  <= wdata_i[GROUPS-1:0];
        default:  ;
      endcase
    end
  end

  logic [MODE_W-1:0] mode_rd;
  always_comb begin
    mode_rd = '1;  // reserved bits read as ones
    mode_rd[GROUPS-1:0] = nov_q;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      REG_NEXT: rdata_o = next_q;
      REG_TSEL: rdata_o[TW-1:0] = tsel_q;
      REG_MODE: rdata_o[MODE_W-1:0] = mode_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign next_o = next_q;
  assign tsel_o = tsel_q;
  assign nov_o  = nov_q;

  // R3
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MODE) |=> nov_o == $past(wdata_i[GROUPS-1:0]));
  // R2
  tsel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_TSEL) |=> tsel_o == $past(wdata_i[TW-1:0]));
endmodule

// File: rtl/pto_group.sv
module pto_group #(
  parameter int GW     = 4,
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GW-1:0]     next_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              nov_i,
  input  logic [NUM_CH-1:0] cm_a_i,
  input  logic [NUM_CH-1:0] cm_b_i,
  output logic [GW-1:0]     out_o
);
  logic          hit_a, hit_b;
  logic [GW-1:0] clr, set, out_q, out_d;

  assign hit_a = cm_a_i[sel_i];
  assign hit_b = cm_b_i[sel_i];

  always_comb begin
    clr = '0;
    set = '0;
    if (nov_i) begin
      if (hit_a) clr = ~next_i;  // falling bits on A
      if (hit_b) set = next_i;   // rising bits on B
      out_d = (out_q & ~clr) | set;
    end else begin
      out_d = hit_a ? next_i : out_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  // R5
  ord_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nov_i && hit_a) |=> out_o == $past(next_i));
  // R6
  nov_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nov_i && hit_a && !hit_b) |=> out_o == ($past(out_o) & $past(next_i)));
  // R7
  nov_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nov_i && hit_b && !hit_a) |=> out_o == ($past(out_o) | $past(next_i)));
  // R8
  nov_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nov_i && hit_a && hit_b) |=> out_o == $past(next_i));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_a && !hit_b) |=> $stable(out_o));
endmodule

// File: rtl/pto_top.sv
module pto_top
  import pto_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GW     = 4,
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH),
  localparam int DW    = GROUPS * GW,
  localparam int TW    = GROUPS * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NUM_CH-1:0] cm_a_i,
  input  logic [NUM_CH-1:0] cm_b_i,
  output logic [DW-1:0]     pattern_o
);
  logic [DW-1:0]     next_data;
  logic [TW-1:0]     tsel;
  logic [GROUPS-1:0] nov;

  pto_regs #(.GROUPS(GROUPS), .GW(GW), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .next_o  (next_data),
    .tsel_o  (tsel),
    .nov_o   (nov)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pto_group #(.GW(GW), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .next_i (next_data[g*GW +: GW]),
      .sel_i  (tsel[g*SEL_W +: SEL_W]),
      .nov_i  (nov[g]),
      .cm_a_i (cm_a_i),
      .cm_b_i (cm_b_i),
      .out_o  (pattern_o[g*GW +: GW])
    );
  end

  // R10
  quiet_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_a_i == '0 && cm_b_i == '0) |=> $stable(pattern_o));
endmodule

// File: tb/pto_top_bench.sv
module pto_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [3:0]  cm_a_i = '0;
  logic [3:0]  cm_b_i = '0;
  logic [15:0] pattern_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pto_top u_pto_top (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic strobe(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk_i);
    cm_a_i = a; cm_b_i = b;
    @(negedge clk_i);
    cm_a_i = '0; cm_b_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 pattern", pattern_o, 16'h0000);
    rd(2'd0, d); check("R1 next", d, 16'h0000);
    rd(2'd1, d); check("R1 tsel", d, 16'h0000);
    rd(2'd2, d); check("R1 mode", d, 16'h00F0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd0, 16'hA5C3); rd(2'd0, d); check("R2 next", d, 16'hA5C3);
    wr(2'd1, 16'hFFE4); rd(2'd1, d); check("R2 tsel", d, 16'h00E4);
    wr(2'd2, 16'h000F); rd(2'd2, d); check("R3 mode", d, 16'h00FF);
    wr(2'd2, 16'hFF05); rd(2'd2, d); check("R3 reserved", d, 16'h00F5);
    wr(2'd3, 16'hFFFF); rd(2'd3, d); check("R2 addr3", d, 16'h0000);
    check("R2 no pattern change", pattern_o, 16'h0000);
  endtask

  task automatic t_ordinary();
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h1234);
    strobe(4'h0, 4'h1); check("R5 B ignored", pattern_o, 16'h0000);
    strobe(4'h2, 4'h0); check("R9 other channel", pattern_o, 16'h0000);
    strobe(4'h1, 4'h0); check("R5 load on A", pattern_o, 16'h1234);
  endtask

  task automatic t_select();
    wr(2'd1, 16'h00E4); wr(2'd0, 16'hFFFF);
    strobe(4'h4, 4'h0); check("R4 ch2 -> g2", pattern_o, 16'h1F34);
    strobe(4'h8, 4'h0); check("R4 ch3 -> g3", pattern_o, 16'hFF34);
    strobe(4'h2, 4'h0); check("R4 ch1 -> g1", pattern_o, 16'hFFF4);
    strobe(4'h1, 4'h0); check("R10 ch0 -> g0", pattern_o, 16'hFFFF);
  endtask

  task automatic t_nonoverlap();
    wr(2'd1, 16'h0000); wr(2'd0, 16'h00FF);
    strobe(4'h1, 4'h0); check("R5 preload", pattern_o, 16'h00FF);
    wr(2'd2, 16'h000F); wr(2'd0, 16'h0F0F);
    strobe(4'h1, 4'h0); check("R6 A clears", pattern_o, 16'h000F);
    strobe(4'h0, 4'h1); check("R7 B sets", pattern_o, 16'h0F0F);
    wr(2'd0, 16'hF0F0);
    strobe(4'h0, 4'h1); check("R7 B only rises", pattern_o, 16'hFFFF);
    strobe(4'h1, 4'h0); check("R6 A only falls", pattern_o, 16'hF0F0);
    wr(2'd0, 16'h3C3C);
    strobe(4'h1, 4'h1); check("R8 A and B", pattern_o, 16'h3C3C);
    strobe(4'hE, 4'hE); check("R9 unselected", pattern_o, 16'h3C3C);
  endtask

  task automatic t_mixed();
    wr(2'd2, 16'h0001); wr(2'd0, 16'h0000);
    strobe(4'h1, 4'h0); check("R10 mixed A", pattern_o, 16'h0000);
    wr(2'd0, 16'hFFFF);
    strobe(4'h0, 4'h1); check("R10 mixed B", pattern_o, 16'h000F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_ordinary();
    t_select();
    t_nonoverlap();
    t_mixed();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule